// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a non-blocking time-slot interchange for serial time-division streams organised in 125 µs frames. It has `NSTR` serial input lanes and `NSTR` serial output lanes. Every lane runs at its own rate, so a channel can move between lanes of different speed. Each received byte is stored in a paged data memory, one page per frame. Each output channel fetches its byte from the page that was filled two frames before.

The routing comes from a connection memory, one entry per output channel. A simple write port loads it. Each entry names a source lane and a source channel and carries an enable bit. A disabled channel leaves its serial pin at high impedance and drops its enable indication. Each input lane has a delay setting that moves its sampling grid later. Each output lane has an advancement setting that moves its transmit grid earlier. A global disable input floats every output at once.

The block is clocked at the bit rate of the fastest stream. A frame is `2**FRAME_LOG2` clock ticks, which is 2048 ticks for 16.384 Mbps at the default setting. All frame, channel and bit positions are counted from an internal frame counter that starts at zero when reset is released.

Top module: `tsi_switch`

## Requirements
- R1: A frame lasts 2**FRAME_LOG2 clocks, and `fp_o` is high only in tick 0. Rate code r (0 = slowest, 3 = fastest, one step per doubling) gives one bit every 2**(3-r) clocks. That is 2**(FRAME_LOG2-6+r) channels per frame, with channel c at stream bits 8c to 8c+7. Bits are sent and received MSB first, and a bit is sampled on the last clock of its period.
- R2: Any output channel can take any channel of any input lane. A connection write sets entry `cm_ch_i` of output lane `cm_str_i` to {`cm_en_i`, `cm_src_str_i`, `cm_src_ch_i`}.
- R3: The input and output lanes choose their rates independently. A byte keeps its value when it crosses between lanes of different rates.
- R4: A byte received in input frame k is sent in output frame k+2, at whatever channel the connection memory maps to it.
- R5: While its entry is disabled, an output channel drives its serial pin to high impedance and holds `tx_oe_o` low. Enable changes take effect only at a channel boundary.
- R6: Input delay d, counted in that lane's bits, makes input frame k begin d bits after the internal frame start. Bits [2:0] of d give the bit shift and the upper bits give whole channels.
- R7: Output advancement a, counted in that lane's bits, makes output frame k begin a bits before the internal frame start.
- R8: While `ode_i` is high, every `tx_oe_o` is low and every serial output floats.
- R9: Reset clears every connection entry, so every output stays disabled until it is written.
- R10: A delay or advancement below a quarter frame of its lane's bits keeps the two-frame delay intact. No output then reads a data page in the same cycle that a write fills it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bit clock of the fastest rate |
| rst_ni | input | 1 | asynchronous reset, active low |
| rx_ser_i | input | NSTR | serial input lanes |
| rx_rate_i | input | NSTR*2 | rate code per input lane |
| rx_dly_i | input | NSTR*FRAME_LOG2 | delay per input lane, in that lane's bits |
| tx_rate_i | input | NSTR*2 | rate code per output lane |
| tx_adv_i | input | NSTR*FRAME_LOG2 | advancement per output lane, in that lane's bits |
| cm_we_i | input | 1 | connection entry write strobe |
| cm_str_i | input | SW | output lane of the entry |
| cm_ch_i | input | CW | output channel of the entry |
| cm_en_i | input | 1 | enable bit of the entry |
| cm_src_str_i | input | SW | source input lane |
| cm_src_ch_i | input | CW | source channel |
| ode_i | input | 1 | global output disable |
| tx_ser_o | output | NSTR | serial output lanes, high impedance when disabled |
| tx_oe_o | output | NSTR | per-channel output enable indication |
| fp_o | output | 1 | frame pulse, high in tick 0 |

## Verification
The hardest case to reach is a byte written late and read early on the same data page. A delayed input finishes the tail of frame k-1 during frame k, and an advanced output already reads for frame k+1 at the end of frame k. The bench gets there with phases that combine mixed rates with delays and advancements close to the quarter-frame bound. It then compares every output bit against a model of the frame and page arithmetic. One phase also raises the global disable for a whole frame in the middle of traffic.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int unsigned NPAGE = 3;

    typedef logic [1:0] page_t;

    // modulo-3 page arithmetic
    function automatic page_t page_add(page_t p, logic [1:0] n);
        logic [2:0] s;
        s = {1'b0, p} + {1'b0, n};
        return (s >= 3'd3) ? page_t'(s - 3'd3) : page_t'(s);
    endfunction

    // clocks per bit is 2**rate_shift
    function automatic logic [1:0] rate_shift(logic [1:0] rate);
        return 2'd3 - rate;
    endfunction

endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase
    import tsi_pkg::*;
#(
    parameter int unsigned FRAME_LOG2 = 11
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    output logic [FRAME_LOG2-1:0] tick_o,
    output page_t                 page_o,
    output logic                  fp_o
);
    localparam logic [FRAME_LOG2-1:0] ONE = 1;

    typedef struct packed {
        logic [FRAME_LOG2-1:0] tick;
        page_t                 page;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = st_q.tick + ONE;
        if (&st_q.tick) begin
            st_d.page = page_add(st_q.page, 2'd1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
    assign page_o = st_q.page;
    assign fp_o   = (st_q.tick == '0);

    // R4
    page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.tick != '0) |-> $stable(st_q.page));

endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane
    import tsi_pkg::*;
#(
    parameter int unsigned FRAME_LOG2 = 11,
    parameter int unsigned NSTR       = 4,
    localparam int unsigned CW        = FRAME_LOG2 - 3
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [FRAME_LOG2-1:0]      tick_i,
    input  page_t                      page_i,
    input  logic [1:0]                 rate_i,
    input  logic [FRAME_LOG2-1:0]      dly_i,
    input  logic                       ser_i,
    input  page_t [NSTR-1:0]           rd_page_i,
    input  logic  [NSTR-1:0][CW-1:0]   rd_ch_i,
    output logic  [NSTR-1:0][7:0]      rd_data_o,
    output logic                       we_o,
    output page_t                      wpage_o
);
    localparam int unsigned FL    = FRAME_LOG2;
    localparam int unsigned MAXCH = 1 << CW;
    localparam int unsigned DEPTH = NPAGE * MAXCH;
    localparam int unsigned AW    = $clog2(DEPTH);

    typedef struct packed {
        logic [7:0] shreg;
    } rx_state_t;

    rx_state_t st_d, st_q;

    logic [7:0]    mem [DEPTH];
    logic [1:0]    shamt;
    logic [FL-1:0] pmask, nbm, raw, eff;
    logic [FL:0]   diff;
    logic          last, borrow, we;
    page_t         wpage;
    logic [CW-1:0] wch;
    logic [7:0]    wbyte;

    function automatic logic [AW-1:0] addr_of(page_t p, logic [CW-1:0] c);
        return AW'(p) * AW'(MAXCH) + AW'(c);
    endfunction

    always_comb begin
        shamt  = rate_shift(rate_i);
        pmask  = ~({FL{1'b1}} << shamt);
        last   = ((tick_i & pmask) == pmask);
        raw    = tick_i >> shamt;
        nbm    = {FL{1'b1}} >> shamt;
        diff   = {1'b0, raw} - {1'b0, dly_i};
        borrow = diff[FL];
        eff    = diff[FL-1:0] & nbm;
        wpage  = borrow ? page_add(page_i, 2'd2) : page_i;
        wch    = eff[FL-1:3];
        wbyte  = {st_q.shreg[6:0], ser_i};
        st_d   = st_q;
        we     = 1'b0;
        if (last) begin
            st_d.shreg = wbyte;
            we         = (eff[2:0] == 3'b111);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (we) begin
            mem[addr_of(wpage, wch)] <= wbyte;
        end
    end

    for (genvar o = 0; o < NSTR; o++) begin : g_rd
        assign rd_data_o[o] = mem[addr_of(rd_page_i[o], rd_ch_i[o])];
    end

    assign we_o    = we;
    assign wpage_o = wpage;

    // checker state: samples since the last byte write
    logic [3:0] gap_q;
    logic       seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (we) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (last && gap_q != 4'hF) begin
            gap_q  <= gap_q + 4'd1;
        end
    end

    // R1
    byte_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we && seen_q) |-> (gap_q == 4'd7));

endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane
    import tsi_pkg::*;
#(
    parameter int unsigned FRAME_LOG2 = 11,
    parameter int unsigned NSTR       = 4,
    localparam int unsigned CW        = FRAME_LOG2 - 3,
    localparam int unsigned SW        = $clog2(NSTR)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [FRAME_LOG2-1:0] tick_i,
    input  page_t                 page_i,
    input  logic [1:0]            rate_i,
    input  logic [FRAME_LOG2-1:0] adv_i,
    input  logic                  cm_we_i,
    input  logic [CW-1:0]         cm_ch_i,
    input  logic                  cm_en_i,
    input  logic [SW-1:0]         cm_src_str_i,
    input  logic [CW-1:0]         cm_src_ch_i,
    input  logic                  ode_i,
    input  logic [7:0]            rd_data_i,
    output logic [SW-1:0]         rd_str_o,
    output page_t                 rd_page_o,
    output logic [CW-1:0]         rd_ch_o,
    output logic                  ld_o,
    output logic                  ser_o,
    output logic                  oe_o
);
    localparam int unsigned FL    = FRAME_LOG2;
    localparam int unsigned MAXCH = 1 << CW;
    localparam logic [FL-1:0] ONE = 1;

    typedef struct packed {
        logic          en;
        logic [SW-1:0] str;
        logic [CW-1:0] ch;
    } cm_entry_t;

    typedef struct packed {
        logic [7:0] shreg;
        logic       dat;
        logic       en;
    } tx_state_t;

    tx_state_t st_d, st_q;
    cm_entry_t cm_q [MAXCH];

    logic [1:0]    shamt;
    logic [FL-1:0] pmask, nbm, raw, nraw, eff;
    logic [FL:0]   sum, nb_ext, eff_w;
    logic          last, wrap, ovf, ld;
    page_t         npage;
    cm_entry_t     ent;

    always_comb begin
        shamt  = rate_shift(rate_i);
        pmask  = ~({FL{1'b1}} << shamt);
        last   = ((tick_i & pmask) == pmask);
        raw    = tick_i >> shamt;
        nbm    = {FL{1'b1}} >> shamt;
        nraw   = (raw + ONE) & nbm;
        wrap   = last && (raw == nbm);
        npage  = wrap ? page_add(page_i, 2'd1) : page_i;
        sum    = {1'b0, nraw} + {1'b0, adv_i};
        nb_ext = {1'b0, nbm} + {1'b0, ONE};
        ovf    = (sum >= nb_ext);
        eff_w  = ovf ? (sum - nb_ext) : sum;
        eff    = eff_w[FL-1:0];
        ent    = cm_q[eff[FL-1:3]];
        ld     = last && (eff[2:0] == 3'b000);
        st_d   = st_q;
        if (ld) begin
            st_d.dat   = rd_data_i[7];
            st_d.shreg = {rd_data_i[6:0], 1'b0};
            st_d.en    = ent.en;
        end else if (last) begin
            st_d.dat   = st_q.shreg[7];
            st_d.shreg = {st_q.shreg[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < MAXCH; i++) begin
                cm_q[i] <= '0;
            end
        end else if (cm_we_i) begin
            cm_q[cm_ch_i] <= '{en: cm_en_i, str: cm_src_str_i, ch: cm_src_ch_i};
        end
    end

    assign rd_str_o  = ent.str;
    assign rd_ch_o   = ent.ch;
    assign rd_page_o = ovf ? page_add(npage, 2'd2) : page_add(npage, 2'd1);
    assign ld_o      = ld;
    assign oe_o      = st_q.en & ~ode_i;
    assign ser_o     = (st_q.en & ~ode_i) ? st_q.dat : 1'bz;

    // R1
    bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !last |=> $stable(st_q.dat));

    // R5
    oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.en) |-> $past(ld));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int unsigned FRAME_LOG2 = 11,
    parameter int unsigned NSTR       = 4,
    localparam int unsigned CW        = FRAME_LOG2 - 3,
    localparam int unsigned SW        = $clog2(NSTR)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NSTR-1:0]                  rx_ser_i,
    input  logic [NSTR-1:0][1:0]             rx_rate_i,
    input  logic [NSTR-1:0][FRAME_LOG2-1:0]  rx_dly_i,
    input  logic [NSTR-1:0][1:0]             tx_rate_i,
    input  logic [NSTR-1:0][FRAME_LOG2-1:0]  tx_adv_i,
    input  logic                             cm_we_i,
    input  logic [SW-1:0]                    cm_str_i,
    input  logic [CW-1:0]                    cm_ch_i,
    input  logic                             cm_en_i,
    input  logic [SW-1:0]                    cm_src_str_i,
    input  logic [CW-1:0]                    cm_src_ch_i,
    input  logic                             ode_i,
    output logic [NSTR-1:0]                  tx_ser_o,
    output logic [NSTR-1:0]                  tx_oe_o,
    output logic                             fp_o
);
    logic [FRAME_LOG2-1:0]         tick;
    page_t                         page;

    page_t [NSTR-1:0]              tx_rpage;
    logic  [NSTR-1:0][CW-1:0]      tx_rch;
    logic  [NSTR-1:0][SW-1:0]      tx_str;
    logic  [NSTR-1:0][7:0]         tx_data;
    logic  [NSTR-1:0]              tx_ld;
    logic  [NSTR-1:0][NSTR-1:0][7:0] rd_bytes;  // [source lane][read port]
    logic  [NSTR-1:0]              rx_we;
    page_t [NSTR-1:0]              rx_wpage;

    tsi_timebase #(.FRAME_LOG2(FRAME_LOG2)) u_tb (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick),
        .page_o (page),
        .fp_o   (fp_o)
    );

    for (genvar s = 0; s < NSTR; s++) begin : g_rx
        tsi_rx_lane #(.FRAME_LOG2(FRAME_LOG2), .NSTR(NSTR)) u_rx (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .tick_i    (tick),
            .page_i    (page),
            .rate_i    (rx_rate_i[s]),
            .dly_i     (rx_dly_i[s]),
            .ser_i     (rx_ser_i[s]),
            .rd_page_i (tx_rpage),
            .rd_ch_i   (tx_rch),
            .rd_data_o (rd_bytes[s]),
            .we_o      (rx_we[s]),
            .wpage_o   (rx_wpage[s])
        );
    end

    for (genvar o = 0; o < NSTR; o++) begin : g_tx
        assign tx_data[o] = rd_bytes[tx_str[o]][o];

        tsi_tx_lane #(.FRAME_LOG2(FRAME_LOG2), .NSTR(NSTR)) u_tx (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .tick_i       (tick),
            .page_i       (page),
            .rate_i       (tx_rate_i[o]),
            .adv_i        (tx_adv_i[o]),
            .cm_we_i      (cm_we_i && (cm_str_i == SW'(o))),
            .cm_ch_i      (cm_ch_i),
            .cm_en_i      (cm_en_i),
            .cm_src_str_i (cm_src_str_i),
            .cm_src_ch_i  (cm_src_ch_i),
            .ode_i        (ode_i),
            .rd_data_i    (tx_data[o]),
            .rd_str_o     (tx_str[o]),
            .rd_page_o    (tx_rpage[o]),
            .rd_ch_o      (tx_rch[o]),
            .ld_o         (tx_ld[o]),
            .ser_o        (tx_ser_o[o]),
            .oe_o         (tx_oe_o[o])
        );
    end

    for (genvar s = 0; s < NSTR; s++) begin : g_clash_s
        for (genvar o = 0; o < NSTR; o++) begin : g_clash_o
            // R10
            no_page_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (rx_we[s] && tx_ld[o] && (tx_str[o] == SW'(s))) |-> (rx_wpage[s] != tx_rpage[o]));
        end
    end

endmodule

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
    localparam int FL    = 8;
    localparam int NS    = 4;
    localparam int CW    = FL - 3;
    localparam int SW    = 2;
    localparam int MAXCH = 1 << CW;
    localparam int FR    = 1 << FL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]          rx_ser = '0;
    logic [NS-1:0][1:0]     rx_rate;
    logic [NS-1:0][FL-1:0]  rx_dly;
    logic [NS-1:0][1:0]     tx_rate;
    logic [NS-1:0][FL-1:0]  tx_adv;
    logic                   cm_we = 1'b0;
    logic [SW-1:0]          cm_str = '0;
    logic [CW-1:0]          cm_ch = '0;
    logic                   cm_en = 1'b0;
    logic [SW-1:0]          cm_sstr = '0;
    logic [CW-1:0]          cm_sch = '0;
    logic                   ode = 1'b0;
    logic [NS-1:0]          tx_ser;
    logic [NS-1:0]          tx_oe;
    logic                   fp;

    int rxr [NS];
    int rxd [NS];
    int txr [NS];
    int txa [NS];
    int m_en  [NS][MAXCH];
    int m_src [NS][MAXCH];
    int m_sch [NS][MAXCH];
    int ph;
    int t;
    int n_chk = 0;
    int n_fail = 0;
    bit active = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            rx_rate[s] = rxr[s][1:0];
            rx_dly[s]  = rxd[s][FL-1:0];
            tx_rate[s] = txr[s][1:0];
            tx_adv[s]  = txa[s][FL-1:0];
        end
    end

    tsi_switch #(.FRAME_LOG2(FL), .NSTR(NS)) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .rx_ser_i     (rx_ser),
        .rx_rate_i    (rx_rate),
        .rx_dly_i     (rx_dly),
        .tx_rate_i    (tx_rate),
        .tx_adv_i     (tx_adv),
        .cm_we_i      (cm_we),
        .cm_str_i     (cm_str),
        .cm_ch_i      (cm_ch),
        .cm_en_i      (cm_en),
        .cm_src_str_i (cm_sstr),
        .cm_src_ch_i  (cm_sch),
        .ode_i        (ode),
        .tx_ser_o     (tx_ser),
        .tx_oe_o      (tx_oe),
        .fp_o         (fp)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) t <= 0;
        else        t <= t + 1;
    end

    function automatic int pat(int k, int s, int c);
        return (((k * 29 + s * 67 + c * 13 + 7) % 256) + 256) % 256;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d phase=%0d)", req, act, exp, t, ph);
        end
    endtask

    always @(negedge clk) begin
        int fr, tk, sh, nb, raw, e, kk, c, pos, of, exp_oe, src, b;
        string lbl;
        if (active) begin
            fr = t / FR;
            tk = t % FR;
            // R1 frame pulse only in tick 0
            chk(fp == (tk == 0), "R1 frame pulse", int'(fp), int'(tk == 0));
            // R9 outputs stay disabled until programmed
            if (fr == 0) begin
                for (int o = 0; o < NS; o++) chk(tx_oe[o] == 1'b0, "R9 cleared entry", int'(tx_oe[o]), 0);
            end
            if (fr >= 4) begin
                case (ph)
                    0: lbl = "R1 R2 R4";
                    1: lbl = "R3 R4";
                    2: lbl = "R4 R6 R7";
                    default: lbl = "R4 R6 R7 R10";
                endcase
                for (int o = 0; o < NS; o++) begin
                    sh  = 3 - txr[o];
                    nb  = FR >> sh;
                    raw = tk >> sh;
                    e   = raw + txa[o];
                    of  = (e >= nb) ? 1 : 0;
                    if (of == 1) e = e - nb;
                    c   = e / 8;
                    pos = e % 8;
                    exp_oe = (m_en[o][c] != 0 && !ode) ? 1 : 0;
                    chk(tx_oe[o] == exp_oe[0], ode ? "R8 global disable" : "R5 enable", int'(tx_oe[o]), exp_oe);
                    if (exp_oe == 1) begin
                        src = m_src[o][c];
                        b = (pat(fr + of - 2, src, m_sch[o][c]) >> (7 - pos)) & 1;
                        chk(tx_ser[o] === b[0], lbl, int'(tx_ser[o]), b);
                    end
                end
            end
            // drive serial inputs for this tick
            for (int s = 0; s < NS; s++) begin
                sh  = 3 - rxr[s];
                nb  = FR >> sh;
                raw = tk >> sh;
                if (raw >= rxd[s]) begin e = raw - rxd[s];      kk = fr;     end
                else               begin e = raw - rxd[s] + nb; kk = fr - 1; end
                c   = e / 8;
                pos = e % 8;
                b = (pat(kk, s, c) >> (7 - pos)) & 1;
                rx_ser[s] = b[0];
            end
            ode = (ph == 3 && fr == 5);
            // program the connection memory during frame 1
            if (fr == 1 && tk < NS * MAXCH) begin
                int o2, c2, s2, nsrc;
                o2   = tk / MAXCH;
                c2   = tk % MAXCH;
                s2   = (o2 + c2 + ph) % NS;
                nsrc = 4 << rxr[s2];
                m_src[o2][c2] = s2;
                m_sch[o2][c2] = (c2 * 3 + o2 + ph) % nsrc;
                m_en[o2][c2]  = (((c2 + 2 * o2 + ph) % 5) != 0) ? 1 : 0;
                cm_we   = 1'b1;
                cm_str  = o2[SW-1:0];
                cm_ch   = c2[CW-1:0];
                cm_en   = m_en[o2][c2][0];
                cm_sstr = s2[SW-1:0];
                cm_sch  = m_sch[o2][c2][CW-1:0];
            end else begin
                cm_we = 1'b0;
            end
        end
    end

    task automatic run_phase(int p);
        ph = p;
        for (int o = 0; o < NS; o++)
            for (int c = 0; c < MAXCH; c++) begin
                m_en[o][c] = 0; m_src[o][c] = 0; m_sch[o][c] = 0;
            end
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        active = 1'b0;
        cm_we = 1'b0;
        ode = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk(tx_oe == '0, "R9 reset state", int'(tx_oe), 0);
        rst_n = 1'b1;
        active = 1'b1;
        wait (t == 7 * FR);
        @(posedge clk);
        #1;
        active = 1'b0;
    endtask

    initial begin
        // phase 0: all lanes at the top rate, no delay
        for (int s = 0; s < NS; s++) begin rxr[s] = 3; txr[s] = 3; rxd[s] = 0; txa[s] = 0; end
        run_phase(0);
        // phase 1: mixed rates in both directions (R3)
        rxr = '{0, 1, 2, 3}; txr = '{3, 2, 1, 0};
        rxd = '{0, 0, 0, 0}; txa = '{0, 0, 0, 0};
        run_phase(1);
        // phase 2: delays and advancements (R6, R7)
        rxr = '{1, 3, 2, 0}; rxd = '{9, 21, 13, 3};
        txr = '{2, 0, 3, 1}; txa = '{10, 5, 30, 7};
        run_phase(2);
        // phase 3: settings near the quarter-frame bound, global disable in frame 5 (R8, R10)
        rxr = '{2, 2, 0, 3}; rxd = '{2, 8, 1, 40};
        txr = '{1, 3, 0, 2}; txa = '{0, 60, 3, 17};
        run_phase(3);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", t, 7 * FR);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule